// File: doc/BRIEF.md
# Pulse Width Window Discriminator

This block watches a single asynchronous pulse line and judges the high time of every positive pulse against two programmable limits: a shortest and a longest acceptable width. Both limits are given in clock cycles. When a pulse falls outside that window, the block raises a one-cycle violation strobe. Two sticky flags record which limit was broken. Pulses that fit the window leave the strobe low.

The input first passes through a synchronizer. Timing then starts on the synchronized leading edge, and one running count serves both limit checks. A pulse that is too short is judged when its trailing edge arrives. A pulse that is too long is judged on the cycle its running width passes the maximum, so the strobe comes out while the pulse is still high. The flags stay set until the next leading edge, which lets a reader tell which limit a pulse violated.

Top module: `pwd_window_disc`

## Requirements
- R1: After reset, `viol_strobe`, `too_short` and `too_long` are all 0, and they stay 0 while the input stays low.
- R2: The width W of a pulse is the number of rising clock edges that sample `pulse_in` high (the input is held for whole cycles). Timing starts at the first such edge, after `SYNC_STAGES` synchronizer flops.
- R3: A pulse with W < `min_width` produces exactly one `viol_strobe` cycle after its trailing edge and sets `too_short`.
- R4: A pulse with W > `max_width` produces exactly one `viol_strobe` cycle, with no wait for the trailing edge. The strobe is first high after edge number `max_width + SYNC_STAGES + 1`, counting from the first edge that samples the input high. The pulse also sets `too_long`.
- R5: A pulse with `min_width` <= W <= `max_width` produces no strobe. Both boundary widths are inside the window.
- R6: `too_short` and `too_long` hold their value through idle time. The next leading edge clears them, and that pulse's own result can set them again.
- R7: A pulse produces at most one strobe, and the two flags are never set together. When `min_width` > `max_width`, every pulse is flagged exactly once. A pulse already reported as too long is not reported again as too short.
- R8: The width count saturates at its all-ones value. With `max_width` at all ones, no pulse is reported as too long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse line under test |
| min_width | input | CNT_W | Shortest accepted width in clocks |
| max_width | input | CNT_W | Longest accepted width in clocks |
| viol_strobe | output | 1 | One-cycle pulse per out-of-window input pulse |
| too_short | output | 1 | Last judged pulse was below the minimum |
| too_long | output | 1 | Last judged pulse exceeded the maximum |

## Verification
The assertions assume that the limits stay still while a pulse is being timed, and that every event they relate to comes from the synchronized level, never from the raw pin. The bench changes `min_width` and `max_width` only while the line has been idle for several cycles. It drives `pulse_in` on falling clock edges, so every pulse spans a whole number of sampled cycles. This makes the measured width equal to the number of cycles the bench held the line high.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  // Saturating increment of a width count.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] top;
    top = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v >= top) ? top : v + 32'd1;
  endfunction

  // True when a running width has gone beyond the allowed maximum.
  function automatic logic over_limit(input logic [31:0] width, input logic [31:0] lim);
    return width > lim;
  endfunction

  // True when a finished width stayed under the required minimum.
  function automatic logic under_limit(input logic [31:0] width, input logic [31:0] lim);
    return width < lim;
  endfunction

endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] stg;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= 1'b0;
    else        stg[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= 1'b0;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= stg[STAGES-1];
  end

  assign level = stg[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/pwd_width_timer.sv
module pwd_width_timer
  import pwd_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             rise,
  output logic [CNT_W-1:0] cur_width,
  output logic [CNT_W-1:0] held_width
);
  logic [CNT_W-1:0] cnt;
  logic [31:0]      inc;

  assign inc       = sat_inc(32'(cnt), CNT_W);
  assign cur_width = rise ? CNT_W'(1) : inc[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (level) cnt <= cur_width;
  end

  assign held_width = cnt;
endmodule

// File: rtl/pwd_judge.sv
module pwd_judge
  import pwd_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] cur_width,
  input  logic [CNT_W-1:0] held_width,
  input  logic [CNT_W-1:0] min_width,
  input  logic [CNT_W-1:0] max_width,
  output logic             short_evt,
  output logic             long_evt,
  output logic             viol_strobe,
  output logic             too_short,
  output logic             too_long
);
  logic long_seen;
  logic long_armed;

  assign long_armed = rise | ~long_seen;
  assign long_evt   = level & long_armed & over_limit(32'(cur_width), 32'(max_width));
  assign short_evt  = fall & ~long_seen & under_limit(32'(held_width), 32'(min_width));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        long_seen <= 1'b0;
    else if (long_evt) long_seen <= 1'b1;
    else if (rise)     long_seen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_strobe <= 1'b0;
      too_short   <= 1'b0;
      too_long    <= 1'b0;
    end else begin
      viol_strobe <= short_evt | long_evt;
      if (rise) begin
        too_short <= 1'b0;
        too_long  <= long_evt;
      end else begin
        if (short_evt) too_short <= 1'b1;
        if (long_evt)  too_long  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwd_window_disc.sv
module pwd_window_disc #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] min_width,
  input  logic [CNT_W-1:0] max_width,
  output logic             viol_strobe,
  output logic             too_short,
  output logic             too_long
);
  logic             pulse_sync;
  logic             lead_edge;
  logic             trail_edge;
  logic [CNT_W-1:0] cur_width;
  logic [CNT_W-1:0] held_width;
  logic             short_evt;
  logic             long_evt;

  pwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pulse_in),
    .level (pulse_sync),
    .rise  (lead_edge),
    .fall  (trail_edge)
  );

  pwd_width_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (pulse_sync),
    .rise       (lead_edge),
    .cur_width  (cur_width),
    .held_width (held_width)
  );

  pwd_judge #(.CNT_W(CNT_W)) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (pulse_sync),
    .rise        (lead_edge),
    .fall        (trail_edge),
    .cur_width   (cur_width),
    .held_width  (held_width),
    .min_width   (min_width),
    .max_width   (max_width),
    .short_evt   (short_evt),
    .long_evt    (long_evt),
    .viol_strobe (viol_strobe),
    .too_short   (too_short),
    .too_long    (too_long)
  );
endmodule

// File: rtl/pwd_window_disc_chk.sv
module pwd_window_disc_chk (
  input logic clk,
  input logic rst_n,
  input logic pulse_sync,
  input logic lead_edge,
  input logic trail_edge,
  input logic short_evt,
  input logic long_evt,
  input logic viol_strobe,
  input logic too_short,
  input logic too_long
);
  // R7: one violation kind per pulse, never both flags
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(too_short && too_long));

  // R3/R4: every strobe comes with a flag that names its cause
  a_r4_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    viol_strobe |-> (too_short || too_long));

  // R1: a strobe follows only a cycle with the line high or just released
  a_r1_strobe_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    viol_strobe |-> $past(pulse_sync || trail_edge));

  // R6: flags only drop after a leading edge
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(too_short) || $fell(too_long)) |-> $past(lead_edge));

  // R3: a short verdict is only reached at a trailing edge
  a_r3_short_at_trail: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |-> (trail_edge && !pulse_sync));

  // R7: no short verdict in the cycle after a long one
  a_r7_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    long_evt |=> !short_evt);
endmodule

bind pwd_window_disc pwd_window_disc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pulse_sync  (pulse_sync),
  .lead_edge   (lead_edge),
  .trail_edge  (trail_edge),
  .short_evt   (short_evt),
  .long_evt    (long_evt),
  .viol_strobe (viol_strobe),
  .too_short   (too_short),
  .too_long    (too_long)
);

// File: tb/tb_pwd_window_disc.sv
`timescale 1ns/1ps
module tb_pwd_window_disc;
  localparam int CNT_W = 12;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_in = 1'b0;
  logic [CNT_W-1:0] min_width = 12'd4;
  logic [CNT_W-1:0] max_width = 12'd8;
  logic             viol_strobe, too_short, too_long;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwd_window_disc #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
    .min_width(min_width), .max_width(max_width),
    .viol_strobe(viol_strobe), .too_short(too_short), .too_long(too_long)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a pulse of w sampled cycles, then idle; returns strobe count and first strobe index.
  task automatic pulse(input int w, output int n_strobe, output int first_at);
    n_strobe = 0;
    first_at = -1;
    @(negedge clk);
    pulse_in = 1'b1;
    for (int j = 0; j < w + 14; j++) begin
      @(negedge clk);
      if (j == w - 1) pulse_in = 1'b0;
      if (viol_strobe) begin
        n_strobe++;
        if (first_at < 0) first_at = j;
      end
    end
  endtask

  task automatic judge(input int w, input bit es, input bit el, input string req);
    int n, f;
    pulse(w, n, f);
    check(n == ((es || el) ? 1 : 0), req, n, (es || el) ? 1 : 0);
    check(too_short == es, req, too_short, es);
    check(too_long == el, req, too_long, el);
  endtask

  task automatic t_reset();
    check(!viol_strobe && !too_short && !too_long, "R1 reset", {viol_strobe, too_short, too_long}, 0);
    repeat (10) @(negedge clk);
    check(!viol_strobe && !too_short && !too_long, "R1 idle", {viol_strobe, too_short, too_long}, 0);
  endtask

  task automatic t_in_window();
    judge(6, 0, 0, "R5 mid");
    judge(4, 0, 0, "R5 w=min");
    judge(8, 0, 0, "R5 w=max");
  endtask

  task automatic t_short();
    judge(3, 1, 0, "R3 w=min-1");
    repeat (20) @(negedge clk);
    check(too_short == 1'b1, "R6 short hold", too_short, 1);
    judge(1, 1, 0, "R3 w=1");
    judge(5, 0, 0, "R6 cleared by good pulse");
  endtask

  task automatic t_long();
    int n, f;
    pulse(9, n, f);
    check(n == 1, "R4 w=max+1 count", n, 1);
    check(f == int'(max_width) + SYNC, "R4 latency", f, int'(max_width) + SYNC);
    check(too_long == 1'b1, "R4 flag", too_long, 1);
    pulse(30, n, f);
    check(n == 1, "R4 once per long pulse", n, 1);
    check(f == int'(max_width) + SYNC, "R4 early report", f, int'(max_width) + SYNC);
    repeat (20) @(negedge clk);
    check(too_long == 1'b1 && too_short == 1'b0, "R6 long hold", too_long, 1);
    judge(2, 1, 0, "R6 long to short");
  endtask

  task automatic t_inverted();
    min_width = 12'd10;
    max_width = 12'd3;
    repeat (4) @(negedge clk);
    judge(2, 1, 0, "R7 inv short");
    judge(5, 0, 1, "R7 inv mid flagged once");
    judge(12, 0, 1, "R7 inv long");
  endtask

  task automatic t_saturate();
    min_width = 12'd1;
    max_width = 12'hFFF;
    repeat (4) @(negedge clk);
    judge(4200, 0, 0, "R8 no long at all-ones");
    max_width = 12'd0;
    repeat (4) @(negedge clk);
    judge(1, 0, 1, "R8 max zero");
    judge(1, 0, 1, "R2 single cycle pulse timed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_in_window();
    t_short();
    t_long();
    t_inverted();
    t_saturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule